// File: doc/BRIEF.md
# Serial Tuning-Word Control Front End

This block receives a tuning control word from a host over a three-wire serial link (a data line, a bit clock and a frame strobe) and turns it into the static settings a frequency synthesiser loop needs. These are the divide ratio, the prescaler select, the reference ratio code, the pump current select, the tuning-drive switch, a test-mode flag and the general-purpose output bits. The three serial lines arrive asynchronously. They are passed through two-flop synchronisers and edge-detected in the faster system clock domain.

A frame opens when the strobe goes high. Each rising bit-clock edge inside the frame shifts in one bit, oldest bit first. When the strobe falls, a frame of exactly the configured length is accepted. A frame of any other length is rejected with a one-cycle error pulse. On acceptance, the reference, pump, drive, test and port fields take effect at once. The divide ratio and prescaler select are parked in a pending stage and copied to the live outputs only when the loop divider reports the end of a count cycle, so a retune never cuts a divider cycle short.

The block also drives the port pins. In test mode the two lowest pins carry the half-rate divider output and the comparison clock in place of their data bits. A pump-off input sends the charge pump to high impedance. Raising that input while test mode is active is flagged as an illegal combination.

Top module: `tune3w_ctrl`

## Requirements
- R1: Bits are shifted only on a rising edge of `ser_clk` while `ser_en` is high; bit-clock edges while `ser_en` is low change no output.
- R2: The word is `17 + NUM_PORTS + 7` bits long (28 for four ports, 26 for two) and is sent oldest bit first. Counting from the last bit received as bit 0, the fields are: bit 0 prescaler select, bits 3..1 reference code, bit 4 pump current select, bit 5 drive disable, bit 6 test mode, bits 7 upward the port bits (lowest port at bit 7), and the top 17 bits the divide ratio.
- R3: When `ser_en` falls after exactly the word length of bits, `ref_code`, `cp_hi_cur`, `port_bits`, `test_mode` and `drv_en` take their new values after the third rising `clk` edge following the fall.
- R4: `div_ratio` and `presc_en` change only on a `clk` edge where `div_tc` is high and an accepted word is pending; they then take the pending values.
- R5: A `div_tc` pulse with nothing pending changes nothing; if several words are accepted before a `div_tc` pulse, the last one is applied.
- R6: When `ser_en` falls after any other bit count (shorter or longer), `frame_err` is high for exactly one cycle, aligned with the cycle in which R3 would have applied, and no setting or pending value changes.
- R7: While `test_mode` is 1, `port_pin[0]` follows `fpd_half` and `port_pin[1]` follows `fcomp`; otherwise every `port_pin` bit equals its `port_bits` bit, and pins above 1 always do.
- R8: `drv_en` is the inverse of the drive-disable field; `cp_hiz` follows `cp_off` two rising `clk` edges after it changes.
- R9: `mode_err` is 1 exactly when `test_mode` is 1 and the synchronised `cp_off` is 1.
- R10: After reset all settings are 0 except `drv_en`, which is 1, and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock (asynchronous) |
| ser_data | input | 1 | Serial data (asynchronous) |
| ser_en | input | 1 | Frame strobe, high during a frame (asynchronous) |
| cp_off | input | 1 | Pump-off request (asynchronous) |
| div_tc | input | 1 | Divider end-of-cycle pulse, synchronous to clk |
| fpd_half | input | 1 | Half-rate divider output for test mode |
| fcomp | input | 1 | Comparison clock for test mode |
| div_ratio | output | 17 | Live divide ratio |
| presc_en | output | 1 | Live divide-by-two prescaler select |
| ref_code | output | 3 | Reference ratio code |
| cp_hi_cur | output | 1 | Pump high-current select |
| drv_en | output | 1 | Tuning-drive enable |
| test_mode | output | 1 | Test mode active |
| port_bits | output | NUM_PORTS | Port field of the last accepted word |
| port_pin | output | NUM_PORTS | Port pins after test-mode override |
| cp_hiz | output | 1 | Charge pump in high impedance |
| mode_err | output | 1 | Test mode with pump off (not permitted) |
| frame_err | output | 1 | One-cycle pulse on a wrong-length frame |

## Verification
Every output has a fixed latency. A strobe fall shows on the control fields and `frame_err` after the third rising clock edge. A pump-off change reaches `cp_hiz` after the second. A `div_tc` pulse moves the divide ratio on the edge that samples it. The test-mode pins follow their sources with no delay. The bench drives all inputs on falling clock edges and advances its reference model right after the rising edge that the requirement names. It compares every output against that model at every falling edge, so an update that comes one cycle early or late is reported.

// File: rtl/tune3w_pkg.sv
package tune3w_pkg;
    localparam int RATIO_W = 17;
    localparam int TAIL_W  = 7;
    localparam int MAX_PORTS = 4;

    // tail field positions, counted from the last received bit
    localparam int F_PRESC = 0;
    localparam int F_REF   = 1;
    localparam int F_CPHI  = 4;
    localparam int F_OS    = 5;
    localparam int F_T0    = 6;
    localparam int F_PORT  = 7;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic               presc;
    } div_cfg_t;

    typedef struct packed {
        logic [2:0]           refc;
        logic                 cphi;
        logic                 os;
        logic                 t0;
        logic [MAX_PORTS-1:0] ports;
    } misc_cfg_t;

    function automatic int word_width(input int np);
        return RATIO_W + np + TAIL_W;
    endfunction
endpackage

// File: rtl/tune3w_sync.sv
module tune3w_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= async_i;
            s2_q <= s1_q;
        end
    end

    assign sync_o = s2_q;
endmodule

// File: rtl/tune3w_shift.sv
module tune3w_shift #(
    parameter int WORD_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdat_s,
    input  logic              sen_s,
    output logic              load_o,
    output logic              len_ok_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int CNT_MAX = WORD_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic              clk_prev;
        logic              en_prev;
        logic [WORD_W-1:0] sr;
        logic [CNT_W-1:0]  cnt;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.clk_prev = sclk_s;
        st_d.en_prev  = sen_s;
        if (!sen_s) begin
            st_d.cnt = '0;
        end else if (sclk_s && !st_q.clk_prev) begin
            st_d.sr = {st_q.sr[WORD_W-2:0], sdat_s};
            if (st_q.cnt != CNT_W'(CNT_MAX))
                st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load_o   = st_q.en_prev && !sen_s;
    assign len_ok_o = (st_q.cnt == CNT_W'(WORD_W));
    assign word_o   = st_q.sr;

    // R1: with the strobe low the shift register holds its content
    a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!sen_s) |=> $stable(word_o));

    // R6: the bit counter never runs past its saturation value
    a_r6_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_W'(CNT_MAX) && sen_s) |=> (st_q.cnt == CNT_W'(CNT_MAX)));
endmodule

// File: rtl/tune3w_regs.sv
module tune3w_regs
    import tune3w_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int WORD_W    = word_width(NUM_PORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              len_ok_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              div_tc,
    output div_cfg_t          div_o,
    output misc_cfg_t         misc_o,
    output logic              pending_o,
    output logic              frame_err_o
);
    localparam int F_RATIO = F_PORT + NUM_PORTS;

    typedef struct packed {
        div_cfg_t  live;
        div_cfg_t  pend;
        logic      pending;
        misc_cfg_t misc;
        logic      ferr;
    } regs_st_t;

    regs_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.ferr = 1'b0;
        if (st_q.pending && div_tc) begin
            st_d.live    = st_q.pend;
            st_d.pending = 1'b0;
        end
        if (load_i) begin
            if (len_ok_i) begin
                st_d.pend.ratio = word_i[F_RATIO +: RATIO_W];
                st_d.pend.presc = word_i[F_PRESC];
                st_d.pending    = 1'b1;
                st_d.misc.refc  = word_i[F_REF +: 3];
                st_d.misc.cphi  = word_i[F_CPHI];
                st_d.misc.os    = word_i[F_OS];
                st_d.misc.t0    = word_i[F_T0];
                st_d.misc.ports = '0;
                st_d.misc.ports[NUM_PORTS-1:0] = word_i[F_PORT +: NUM_PORTS];
            end else begin
                st_d.ferr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign div_o       = st_q.live;
    assign misc_o      = st_q.misc;
    assign pending_o   = st_q.pending;
    assign frame_err_o = st_q.ferr;

    // R4: the live divider settings move only on a terminal-count cycle
    a_r4_ratio_waits_tc: assert property (@(posedge clk) disable iff (!rst_n)
        (!div_tc) |=> $stable(div_o));

    // R5: a terminal count drains the pending stage unless a new word lands
    a_r5_pending_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && div_tc && !load_i) |=> !pending_o);

    // R6: a rejected frame leaves every setting as it was
    a_r6_bad_frame_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !len_ok_i) |=> ($stable(misc_o) && frame_err_o));
endmodule

// File: rtl/tune3w_ctrl.sv
module tune3w_ctrl
    import tune3w_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    localparam int WORD_W   = word_width(NUM_PORTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_clk,
    input  logic                 ser_data,
    input  logic                 ser_en,
    input  logic                 cp_off,
    input  logic                 div_tc,
    input  logic                 fpd_half,
    input  logic                 fcomp,
    output logic [RATIO_W-1:0]   div_ratio,
    output logic                 presc_en,
    output logic [2:0]           ref_code,
    output logic                 cp_hi_cur,
    output logic                 drv_en,
    output logic                 test_mode,
    output logic [NUM_PORTS-1:0] port_bits,
    output logic [NUM_PORTS-1:0] port_pin,
    output logic                 cp_hiz,
    output logic                 mode_err,
    output logic                 frame_err
);
    logic [3:0]        sync_s;
    logic              load, len_ok, pending;
    logic [WORD_W-1:0] word;
    div_cfg_t          div_cfg;
    misc_cfg_t         misc_cfg;

    tune3w_sync #(.W(4)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cp_off, ser_en, ser_data, ser_clk}),
        .sync_o  (sync_s)
    );

    tune3w_shift #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (sync_s[0]),
        .sdat_s   (sync_s[1]),
        .sen_s    (sync_s[2]),
        .load_o   (load),
        .len_ok_o (len_ok),
        .word_o   (word)
    );

    tune3w_regs #(.NUM_PORTS(NUM_PORTS), .WORD_W(WORD_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .len_ok_i    (len_ok),
        .word_i      (word),
        .div_tc      (div_tc),
        .div_o       (div_cfg),
        .misc_o      (misc_cfg),
        .pending_o   (pending),
        .frame_err_o (frame_err)
    );

    assign div_ratio = div_cfg.ratio;
    assign presc_en  = div_cfg.presc;
    assign ref_code  = misc_cfg.refc;
    assign cp_hi_cur = misc_cfg.cphi;
    assign drv_en    = !misc_cfg.os;
    assign test_mode = misc_cfg.t0;
    assign port_bits = misc_cfg.ports[NUM_PORTS-1:0];
    assign cp_hiz    = sync_s[3];
    assign mode_err  = misc_cfg.t0 && sync_s[3];

    for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_pin
        if (gi == 0) begin : g_fpd
            assign port_pin[gi] = misc_cfg.t0 ? fpd_half : misc_cfg.ports[gi];
        end else if (gi == 1) begin : g_fcmp
            assign port_pin[gi] = misc_cfg.t0 ? fcomp : misc_cfg.ports[gi];
        end else begin : g_plain
            assign port_pin[gi] = misc_cfg.ports[gi];
        end
    end

    // R7: test mode routes the divider half-rate signal to pin 0
    a_r7_pin0_test: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> (port_pin[0] == fpd_half));

    // R9: the illegal combination is always reported
    a_r9_mode_err: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && cp_hiz) |-> mode_err);

    // R8: the pump-off request reaches cp_hiz two edges later
    a_r8_hiz_latency: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cp_off, 2) && $past(rst_n, 2)) |-> cp_hiz);
endmodule

// File: tb/tune3w_ctrl_test.sv
`timescale 1ns/1ps
module tune3w_ctrl_test;
    localparam int NP = 4;
    localparam int W  = 28;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, ser_clk, ser_data, ser_en, cp_off, div_tc, fpd_half, fcomp;
    logic [16:0]   div_ratio;
    logic          presc_en, cp_hi_cur, drv_en, test_mode, cp_hiz, mode_err, frame_err;
    logic [2:0]    ref_code;
    logic [NP-1:0] port_bits, port_pin;

    tune3w_ctrl #(.NUM_PORTS(NP)) uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_en(ser_en), .cp_off(cp_off), .div_tc(div_tc), .fpd_half(fpd_half),
        .fcomp(fcomp), .div_ratio(div_ratio), .presc_en(presc_en),
        .ref_code(ref_code), .cp_hi_cur(cp_hi_cur), .drv_en(drv_en),
        .test_mode(test_mode), .port_bits(port_bits), .port_pin(port_pin),
        .cp_hiz(cp_hiz), .mode_err(mode_err), .frame_err(frame_err)
    );

    int checks = 0;
    int errors = 0;
    bit run  = 1'b0;
    bit done = 1'b0;

    // reference model state
    int exp_ratio = 0, pend_ratio = 0;
    bit exp_presc = 0, pend_presc = 0, pend_valid = 0;
    int exp_ref = 0, exp_ports = 0;
    bit exp_cphi = 0, exp_os = 0, exp_t0 = 0, exp_dis = 0, exp_ferr = 0;

    task automatic chk(input string tag, input int act, input int expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    // test-mode sources change at rising edges only
    logic [2:0] fcnt = '0;
    always @(posedge clk) fcnt <= fcnt + 3'd1;
    assign fpd_half = fcnt[1];
    assign fcomp    = fcnt[2];

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (run) begin
            int ep;
            ep = exp_ports;
            if (exp_t0) begin
                ep[0] = fpd_half;
                ep[1] = fcomp;
            end
            chk("R4 div_ratio", int'(div_ratio), exp_ratio);
            chk("R4 presc_en", int'(presc_en), int'(exp_presc));
            chk("R3 ref_code", int'(ref_code), exp_ref);
            chk("R3 cp_hi_cur", int'(cp_hi_cur), int'(exp_cphi));
            chk("R3 port_bits", int'(port_bits), exp_ports);
            chk("R7 test_mode", int'(test_mode), int'(exp_t0));
            chk("R7 port_pin", int'(port_pin), ep);
            chk("R8 drv_en", int'(drv_en), int'(!exp_os));
            chk("R8 cp_hiz", int'(cp_hiz), int'(exp_dis));
            chk("R9 mode_err", int'(mode_err), int'(exp_t0 && exp_dis));
            chk("R6 frame_err", int'(frame_err), int'(exp_ferr));
        end
    end

    function automatic logic [31:0] mk(input logic [16:0] r, input logic [3:0] p,
                                       input logic t0, input logic os, input logic c0,
                                       input logic [2:0] rc, input logic de);
        return {4'b0, r, p, t0, os, c0, rc, de};
    endfunction

    // R2: oldest bit first; frame accepted only at the word length
    task automatic send(input logic [31:0] v, input int n);
        @(negedge clk) ser_en = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = v[i];
            repeat (3) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
        ser_en = 1'b0;
        repeat (3) @(posedge clk);
        if (n == W) begin
            exp_presc  = exp_presc;
            pend_presc = v[0];
            exp_ref    = int'(v[3:1]);
            exp_cphi   = v[4];
            exp_os     = v[5];
            exp_t0     = v[6];
            exp_ports  = int'(v[7 +: NP]);
            pend_ratio = int'(v[7+NP +: 17]);
            pend_valid = 1'b1;
        end else begin
            exp_ferr = 1'b1;
        end
        @(posedge clk);
        exp_ferr = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_tc();
        @(negedge clk) div_tc = 1'b1;
        @(posedge clk);
        if (pend_valid) begin
            exp_ratio  = pend_ratio;
            exp_presc  = pend_presc;
            pend_valid = 1'b0;
        end
        @(negedge clk) div_tc = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic set_dis(input bit v);
        @(negedge clk) cp_off = v;
        repeat (2) @(posedge clk);
        exp_dis = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; ser_clk = 1'b0; ser_data = 1'b0; ser_en = 1'b0;
        cp_off = 1'b0; div_tc = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        run = 1'b1;

        // R10: reset state
        chk("R10 div_ratio", int'(div_ratio), 0);
        chk("R10 ref_code", int'(ref_code), 0);
        chk("R10 drv_en", int'(drv_en), 1);
        chk("R10 port_bits", int'(port_bits), 0);

        // R1: bit-clock edges with the strobe low are ignored
        ser_data = 1'b1;
        for (int k = 0; k < 5; k++) begin
            repeat (3) @(negedge clk); ser_clk = 1'b1;
            repeat (3) @(negedge clk); ser_clk = 1'b0;
        end
        repeat (4) @(negedge clk);
        chk("R1 ref_code idle", int'(ref_code), 0);
        pulse_tc();
        chk("R1 div_ratio idle", int'(div_ratio), 0);

        // R2/R3/R4: first word; ratio waits for the terminal count
        send(mk(17'h12345, 4'b1010, 1'b0, 1'b0, 1'b1, 3'b101, 1'b1), W);
        chk("R3 ref_code loaded", int'(ref_code), 5);
        chk("R4 ratio held before tc", int'(div_ratio), 0);
        repeat (20) @(negedge clk);
        chk("R4 ratio still held", int'(div_ratio), 0);
        pulse_tc();
        chk("R2 ratio field", int'(div_ratio), 32'h12345);
        chk("R2 port field", int'(port_bits), 4'b1010);
        chk("R2 prescaler field", int'(presc_en), 1);

        // R5: empty tc, then last of two words wins
        pulse_tc();
        chk("R5 empty tc keeps ratio", int'(div_ratio), 32'h12345);
        send(mk(17'h000F0, 4'b0011, 1'b0, 1'b0, 1'b0, 3'b001, 1'b1), W);
        send(mk(17'h1FFFF, 4'b0101, 1'b0, 1'b0, 1'b0, 3'b010, 1'b0), W);
        pulse_tc();
        chk("R5 last word wins", int'(div_ratio), 32'h1FFFF);
        chk("R5 prescaler from last word", int'(presc_en), 0);

        // R6: short and long frames are rejected
        send(32'h000003FF, 10);
        chk("R6 short keeps ref", int'(ref_code), 2);
        send(32'h2AAAAAAA, 30);
        chk("R6 long keeps ports", int'(port_bits), 4'b0101);
        pulse_tc();
        chk("R6 nothing pending", int'(div_ratio), 32'h1FFFF);

        // R7/R8: test mode with drive disabled
        send(mk(17'h00101, 4'b1100, 1'b1, 1'b1, 1'b0, 3'b111, 1'b1), W);
        repeat (16) @(negedge clk);
        chk("R8 drv_en off", int'(drv_en), 0);
        chk("R7 pin3 plain", int'(port_pin[3]), 1);

        // R9: pump off during test mode
        set_dis(1'b1);
        chk("R9 mode_err set", int'(mode_err), 1);
        chk("R8 cp_hiz set", int'(cp_hiz), 1);
        send(mk(17'h00555, 4'b0110, 1'b0, 1'b0, 1'b1, 3'b011, 1'b0), W);
        chk("R9 mode_err clear", int'(mode_err), 0);
        chk("R7 pins follow bits", int'(port_pin), 4'b0110);
        set_dis(1'b0);
        pulse_tc();
        chk("R4 final ratio", int'(div_ratio), 32'h00555);

        run  = 1'b0;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            run = 1'b0;
            checks++;
            errors++;
            $display("FAIL watchdog R10 actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule